// File: doc/BRIEF.md
# 2D Blit Command Decoder

This block sits in front of a rectangle copy engine. It takes a stream of 32-bit command words, one word per valid/ready handshake. It turns each source-to-destination copy command into a parameter record: both pitches in bytes, rectangle width and height, both base addresses, and a tiled flag for each surface. The record is presented with a valid/ready pair. The command stream stalls while a record waits for the consumer, so the record stays stable until it is taken.

The `addr64_i` input selects the address mode. In narrow mode an address takes one word. In wide mode it takes two words, low word first. The copy header's length field must match the mode. A mismatch raises a one-cycle error and the decoder looks for the next header. A flush command is skipped together with its payload words, whose number depends on the mode. An end-of-batch command halts decoding until reset. Any other word seen where a header is expected is dropped.

Top module: `blit_cmd_decoder`

## Requirements
- R1: While `rst_n` is low and after its release, `cmd_ready_o` is 1 and `rec_valid_o`, `len_err_o` and `halted_o` are 0.
- R2: A word with bits 31:24 = 0x54 is a copy header and its bits 7:0 give the word count minus 2. With `addr64_i`=0 the length 6 is accepted and 7 more words follow: dst pitch, dst origin, dimensions, dst address, src origin, src pitch, src address. The upper 32 bits of both record addresses are 0.
- R3: With `addr64_i`=1 (sampled at the header) the length 8 is accepted and 9 more words follow. Each address is two words, low word first: dst low, dst high, src origin, src pitch, src low, src high.
- R4: Bits 31:16 of the dimensions word give the height and bits 15:0 give the width.
- R5: Header bit 15 marks the source as tiled and bit 11 marks the destination as tiled. The pitch field is bits 15:0 of the dst and src pitch words. The record's pitch equals the field for a linear surface and four times the field for a tiled one.
- R6: `rec_valid_o` rises in the cycle after the last word of a copy is accepted. It stays high with all fields unchanged until `rec_ready_i` is sampled high. `cmd_ready_o` is 0 while it is high.
- R7: A copy header whose length does not match the mode drives `len_err_o` high for exactly the next cycle and produces no record. Decoding restarts at the following word, which is treated as a header.
- R8: A header with bits 31:24 = 0x13 is a flush. Its next 2 words (narrow) or 3 words (wide) are discarded unread, even if they look like headers, and no record is produced.
- R9: A header with bits 31:24 = 0x0A ends the batch. From the next cycle `halted_o` is 1 and `cmd_ready_o` is 0 until reset.
- R10: Any other word accepted where a header is expected is dropped with no record, no error and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr64_i | input | 1 | Address mode: 1 = two-word addresses |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_data_i | input | 32 | Command word |
| cmd_ready_o | output | 1 | Decoder accepts a word |
| rec_valid_o | output | 1 | Decoded copy record valid |
| rec_ready_i | input | 1 | Consumer takes the record |
| rec_dst_pitch_o | output | 18 | Destination pitch in bytes |
| rec_src_pitch_o | output | 18 | Source pitch in bytes |
| rec_width_o | output | 16 | Rectangle width |
| rec_height_o | output | 16 | Rectangle height |
| rec_dst_addr_o | output | 64 | Destination base address |
| rec_src_addr_o | output | 64 | Source base address |
| rec_dst_tiled_o | output | 1 | Destination surface tiled |
| rec_src_tiled_o | output | 1 | Source surface tiled |
| len_err_o | output | 1 | One-cycle length mismatch error |
| halted_o | output | 1 | End of batch reached |

## Verification
A wrong word counter or a wrong address mode misplaces fields. The first record after the fault shows a swapped pitch, address or dimension, in the cycle `rec_valid_o` rises. A miscounted flush or copy length puts the decoder out of step with the stream. The next header is then either missed or taken from payload, so `rec_valid_o`, `len_err_o` or `cmd_ready_o` diverge from the reference model within a command or two. The model compares these every cycle and checks the fields whenever a record is pending.

// File: rtl/blit_dec_pkg.sv
package blit_dec_pkg;
    localparam int WORD_W       = 32;
    localparam int OPC_LSB      = 24;
    localparam int LEN_W        = 8;
    localparam int SRC_TILE_BIT = 15;
    localparam int DST_TILE_BIT = 11;
    localparam int CNT_W        = 4;

    localparam logic [7:0] OPC_COPY  = 8'h54;
    localparam logic [7:0] OPC_FLUSH = 8'h13;
    localparam logic [7:0] OPC_END   = 8'h0A;

    localparam logic [LEN_W-1:0] LEN_NARROW = 8'd6;
    localparam logic [LEN_W-1:0] LEN_WIDE   = 8'd8;
    localparam logic [CNT_W-1:0] FLUSH_PAY_NARROW = 4'd2;
    localparam logic [CNT_W-1:0] FLUSH_PAY_WIDE   = 4'd3;

    typedef enum logic [2:0] {
        HK_OTHER, HK_COPY, HK_BADLEN, HK_FLUSH, HK_END
    } hdr_kind_e;

    typedef enum logic [2:0] {
        WR_NONE, WR_DPITCH, WR_DIMS, WR_DLO, WR_DHI, WR_SPITCH, WR_SLO, WR_SHI
    } word_role_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_COPY, ST_SKIP, ST_HALT
    } dec_state_e;
endpackage

// File: rtl/blit_hdr_decode.sv
module blit_hdr_decode
    import blit_dec_pkg::*;
(
    input  logic [WORD_W-1:0]  word_i,
    input  logic               wide_i,
    output hdr_kind_e          kind_o,
    output logic [CNT_W-1:0]   payload_o,
    output logic               src_tiled_o,
    output logic               dst_tiled_o
);
    logic [7:0]       opc;
    logic [LEN_W-1:0] len;

    always_comb begin
        opc         = word_i[OPC_LSB +: 8];
        len         = word_i[LEN_W-1:0];
        src_tiled_o = word_i[SRC_TILE_BIT];
        dst_tiled_o = word_i[DST_TILE_BIT];
        kind_o      = HK_OTHER;
        payload_o   = '0;
        case (opc)
            OPC_COPY: begin
                if (len == (wide_i ? LEN_WIDE : LEN_NARROW)) begin
                    kind_o    = HK_COPY;
                    payload_o = CNT_W'(len + 1'b1);
                end else begin
                    kind_o = HK_BADLEN;
                end
            end
            OPC_FLUSH: begin
                kind_o    = HK_FLUSH;
                payload_o = wide_i ? FLUSH_PAY_WIDE : FLUSH_PAY_NARROW;
            end
            OPC_END: kind_o = HK_END;
            default: kind_o = HK_OTHER;
        endcase
    end
endmodule

// File: rtl/blit_word_role.sv
module blit_word_role
    import blit_dec_pkg::*;
(
    input  logic [CNT_W-1:0] idx_i,
    input  logic             wide_i,
    output word_role_e       role_o
);
    always_comb begin
        role_o = WR_NONE;
        case (idx_i)
            4'd1: role_o = WR_DPITCH;
            4'd3: role_o = WR_DIMS;
            4'd4: role_o = WR_DLO;
            4'd5: role_o = wide_i ? WR_DHI : WR_NONE;
            4'd6: role_o = wide_i ? WR_NONE : WR_SPITCH;
            4'd7: role_o = wide_i ? WR_SPITCH : WR_SLO;
            4'd8: role_o = wide_i ? WR_SLO : WR_NONE;
            4'd9: role_o = wide_i ? WR_SHI : WR_NONE;
            default: role_o = WR_NONE;
        endcase
    end
endmodule

// File: rtl/blit_pitch_scale.sv
module blit_pitch_scale #(
    parameter int FIELD_W = 16,
    localparam int BYTE_W = FIELD_W + 2
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic               tiled_i,
    output logic [BYTE_W-1:0]  bytes_o
);
    always_comb begin
        if (tiled_i) bytes_o = {field_i, 2'b00};
        else         bytes_o = {2'b00, field_i};
    end
endmodule

// File: rtl/blit_cmd_decoder.sv
module blit_cmd_decoder
    import blit_dec_pkg::*;
#(
    parameter int PITCH_W = 16,
    parameter int DIM_W   = 16,
    localparam int PBYTE_W = PITCH_W + 2,
    localparam int ADDR_W  = 2 * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr64_i,
    input  logic               cmd_valid_i,
    input  logic [WORD_W-1:0]  cmd_data_i,
    output logic               cmd_ready_o,
    output logic               rec_valid_o,
    input  logic               rec_ready_i,
    output logic [PBYTE_W-1:0] rec_dst_pitch_o,
    output logic [PBYTE_W-1:0] rec_src_pitch_o,
    output logic [DIM_W-1:0]   rec_width_o,
    output logic [DIM_W-1:0]   rec_height_o,
    output logic [ADDR_W-1:0]  rec_dst_addr_o,
    output logic [ADDR_W-1:0]  rec_src_addr_o,
    output logic               rec_dst_tiled_o,
    output logic               rec_src_tiled_o,
    output logic               len_err_o,
    output logic               halted_o
);
    typedef struct packed {
        dec_state_e          st;
        logic [CNT_W-1:0]    rem;
        logic [CNT_W-1:0]    idx;
        logic                wide;
        logic                dst_t;
        logic                src_t;
        logic [PITCH_W-1:0]  dpf;
        logic [PITCH_W-1:0]  spf;
        logic [DIM_W-1:0]    wid;
        logic [DIM_W-1:0]    hgt;
        logic [ADDR_W-1:0]   daddr;
        logic [ADDR_W-1:0]   saddr;
        logic                rvalid;
        logic                lerr;
    } dec_t;

    dec_t q, d;

    hdr_kind_e        hk;
    logic [CNT_W-1:0] hpay;
    logic             h_src_t, h_dst_t;
    word_role_e       role;
    logic             fire;

    blit_hdr_decode u_hdr (
        .word_i      (cmd_data_i),
        .wide_i      (addr64_i),
        .kind_o      (hk),
        .payload_o   (hpay),
        .src_tiled_o (h_src_t),
        .dst_tiled_o (h_dst_t)
    );

    blit_word_role u_role (
        .idx_i  (q.idx),
        .wide_i (q.wide),
        .role_o (role)
    );

    logic [1:0][PITCH_W-1:0] pf_in;
    logic [1:0]              pt_in;
    logic [1:0][PBYTE_W-1:0] pb_out;

    assign pf_in = {q.spf, q.dpf};
    assign pt_in = {q.src_t, q.dst_t};

    for (genvar s = 0; s < 2; s++) begin : g_pitch
        blit_pitch_scale #(.FIELD_W(PITCH_W)) u_scale (
            .field_i (pf_in[s]),
            .tiled_i (pt_in[s]),
            .bytes_o (pb_out[s])
        );
    end

    assign cmd_ready_o = !q.rvalid && (q.st != ST_HALT);
    assign fire        = cmd_valid_i && cmd_ready_o;

    always_comb begin
        d      = q;
        d.lerr = 1'b0;
        if (q.rvalid && rec_ready_i) d.rvalid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (fire) begin
                    case (hk)
                        HK_COPY: begin
                            d.st    = ST_COPY;
                            d.rem   = hpay;
                            d.idx   = 4'd1;
                            d.wide  = addr64_i;
                            d.dst_t = h_dst_t;
                            d.src_t = h_src_t;
                            d.daddr = '0;
                            d.saddr = '0;
                        end
                        HK_BADLEN: d.lerr = 1'b1;
                        HK_FLUSH: begin
                            d.st  = ST_SKIP;
                            d.rem = hpay;
                        end
                        HK_END:  d.st = ST_HALT;
                        default: d.st = ST_IDLE;
                    endcase
                end
            end
            ST_COPY: begin
                if (fire) begin
                    case (role)
                        WR_DPITCH: d.dpf = cmd_data_i[PITCH_W-1:0];
                        WR_DIMS: begin
                            d.hgt = cmd_data_i[16 +: DIM_W];
                            d.wid = cmd_data_i[DIM_W-1:0];
                        end
                        WR_DLO:    d.daddr[WORD_W-1:0]      = cmd_data_i;
                        WR_DHI:    d.daddr[ADDR_W-1:WORD_W] = cmd_data_i;
                        WR_SPITCH: d.spf = cmd_data_i[PITCH_W-1:0];
                        WR_SLO:    d.saddr[WORD_W-1:0]      = cmd_data_i;
                        WR_SHI:    d.saddr[ADDR_W-1:WORD_W] = cmd_data_i;
                        default:   d.st = ST_COPY;
                    endcase
                    d.idx = q.idx + 1'b1;
                    d.rem = q.rem - 1'b1;
                    if (q.rem == 4'd1) begin
                        d.st     = ST_IDLE;
                        d.rvalid = 1'b1;
                    end
                end
            end
            ST_SKIP: begin
                if (fire) begin
                    d.rem = q.rem - 1'b1;
                    if (q.rem == 4'd1) d.st = ST_IDLE;
                end
            end
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rec_valid_o     = q.rvalid;
    assign rec_dst_pitch_o = pb_out[0];
    assign rec_src_pitch_o = pb_out[1];
    assign rec_width_o     = q.wid;
    assign rec_height_o    = q.hgt;
    assign rec_dst_addr_o  = q.daddr;
    assign rec_src_addr_o  = q.saddr;
    assign rec_dst_tiled_o = q.dst_t;
    assign rec_src_tiled_o = q.src_t;
    assign len_err_o       = q.lerr;
    assign halted_o        = (q.st == ST_HALT);

    // R6: a pending record does not move until it is taken
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_dst_addr_o)
            && $stable(rec_src_addr_o) && $stable(rec_width_o)
            && $stable(rec_height_o) && $stable(rec_dst_pitch_o)
            && $stable(rec_src_pitch_o));

    // R6: the stream is held while a record waits
    a_r6_stall_stream: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> !cmd_ready_o);

    // R9: halt is sticky and blocks the stream
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o && !cmd_ready_o);

    // R7: a length error never comes with a record
    a_r7_err_no_record: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> !rec_valid_o);

    // R5: a tiled surface reports a pitch that is a multiple of four
    a_r5_tiled_pitch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o && rec_dst_tiled_o |-> rec_dst_pitch_o[1:0] == 2'b00);

    // R1: nothing is pending in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rec_valid_o && !len_err_o && !halted_o);
endmodule

// File: tb/blit_cmd_decoder_test.sv
module blit_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr64 = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        cmd_ready;
    logic        rec_valid;
    logic        rec_ready = 1'b0;
    logic [17:0] dpitch, spitch;
    logic [15:0] width, height;
    logic [63:0] daddr, saddr;
    logic        dtiled, stiled, len_err, halted;

    always #2 clk = ~clk;

    blit_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr64_i(addr64),
        .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data), .cmd_ready_o(cmd_ready),
        .rec_valid_o(rec_valid), .rec_ready_i(rec_ready),
        .rec_dst_pitch_o(dpitch), .rec_src_pitch_o(spitch),
        .rec_width_o(width), .rec_height_o(height),
        .rec_dst_addr_o(daddr), .rec_src_addr_o(saddr),
        .rec_dst_tiled_o(dtiled), .rec_src_tiled_o(stiled),
        .len_err_o(len_err), .halted_o(halted)
    );

    int checks = 0, fails = 0, cyc = 0, recs = 0, errs = 0;
    bit finished = 0;
    int unsigned stream[$];
    bit fired = 0;

    // reference model state
    bit          m_valid, m_err, m_halt, m_wide;
    int          m_need, m_kind;
    int unsigned m_words[$];
    logic [17:0] e_dp, e_sp;
    logic [15:0] e_w, e_h;
    logic [63:0] e_da, e_sa;
    bit          e_dt, e_st;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_valid = 0; m_err = 0; m_halt = 0; m_need = 0; m_kind = 0;
        m_words.delete();
    endtask

    function automatic logic [17:0] scale(input logic [15:0] f, input bit t);
        return t ? {f, 2'b00} : {2'b00, f};
    endfunction

    always @(posedge clk) begin
        bit f, e_next;
        int unsigned w;
        cyc++;
        if (!rst_n) begin
            model_clear();
            fired = 0;
        end else begin
            if (rec_valid && rec_ready) recs++;
            if (len_err) errs++;
            f = cmd_valid && !m_valid && !m_halt;
            fired = f;
            e_next = 0;
            if (m_valid && rec_ready) m_valid = 0;
            if (f) begin
                w = cmd_data;
                if (m_need == 0) begin
                    case (w[31:24])
                        8'h54: begin
                            if (w[7:0] == (addr64 ? 8 : 6)) begin
                                m_wide = addr64; m_kind = 1;
                                m_need = w[7:0] + 1;
                                m_words.delete(); m_words.push_back(w);
                            end else e_next = 1;
                        end
                        8'h13: begin m_kind = 2; m_need = addr64 ? 3 : 2; end
                        8'h0A: m_halt = 1;
                        default: ;
                    endcase
                end else begin
                    m_words.push_back(w);
                    m_need--;
                    if (m_need == 0 && m_kind == 1) begin
                        e_dt = m_words[0][11];
                        e_st = m_words[0][15];
                        e_dp = scale(m_words[1][15:0], e_dt);
                        e_h  = m_words[3][31:16];
                        e_w  = m_words[3][15:0];
                        if (m_wide) begin
                            e_da = {32'(m_words[5]), 32'(m_words[4])};
                            e_sp = scale(m_words[7][15:0], e_st);
                            e_sa = {32'(m_words[9]), 32'(m_words[8])};
                        end else begin
                            e_da = {32'h0, 32'(m_words[4])};
                            e_sp = scale(m_words[6][15:0], e_st);
                            e_sa = {32'h0, 32'(m_words[7])};
                        end
                        m_valid = 1;
                    end
                end
            end
            m_err = e_next;
        end
        if (cyc > 60000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<60000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // per-cycle comparison and stimulus drive, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cmd_ready == (!m_valid && !m_halt), m_halt ? "R9" : "R6",
                "cmd_ready", cmd_ready, !m_valid && !m_halt);
            chk(rec_valid == m_valid, "R2", "rec_valid", rec_valid, m_valid);
            chk(len_err == m_err, "R7", "len_err", len_err, m_err);
            chk(halted == m_halt, "R9", "halted", halted, m_halt);
            if (m_valid) begin
                chk(width == e_w, "R4", "width", width, e_w);
                chk(height == e_h, "R4", "height", height, e_h);
                chk(dpitch == e_dp, "R5", "dst pitch", dpitch, e_dp);
                chk(spitch == e_sp, "R5", "src pitch", spitch, e_sp);
                chk(dtiled == e_dt, "R5", "dst tiled", dtiled, e_dt);
                chk(stiled == e_st, "R5", "src tiled", stiled, e_st);
                chk(daddr == e_da, m_wide ? "R3" : "R2", "dst addr", daddr, e_da);
                chk(saddr == e_sa, m_wide ? "R3" : "R2", "src addr", saddr, e_sa);
            end
            if (fired && stream.size() > 0) void'(stream.pop_front());
        end
        cmd_valid = (stream.size() > 0) && (cyc % 5 != 2);
        cmd_data  = (stream.size() > 0) ? stream[0] : 32'h0;
        rec_ready = (cyc % 7) < 3;
    end

    task automatic push_copy(input bit wide, input int len, input bit st, input bit dt,
                             input logic [15:0] dpf, input logic [15:0] spf,
                             input logic [15:0] w, input logic [15:0] h,
                             input logic [63:0] da, input logic [63:0] sa);
        stream.push_back(32'h5400_0000 | (32'(st) << 15) | (32'(dt) << 11) | 32'(len));
        stream.push_back({16'h03CC, dpf});
        stream.push_back(32'h0);
        stream.push_back({h, w});
        stream.push_back(da[31:0]);
        if (wide) stream.push_back(da[63:32]);
        stream.push_back(32'h0);
        stream.push_back({16'h0, spf});
        stream.push_back(sa[31:0]);
        if (wide) stream.push_back(sa[63:32]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        stream.delete();
        repeat (2) @(negedge clk);
        chk(cmd_ready == 1, "R1", "ready in reset", cmd_ready, 1);
        chk(rec_valid == 0 && len_err == 0 && halted == 0, "R1", "flags in reset",
            {rec_valid, len_err, halted}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_ready == 1 && halted == 0, "R1", "after release", {cmd_ready, halted}, 2);
    endtask

    task automatic wait_halt();
        int guard = 0;
        while (!m_halt && guard < 5000) begin @(negedge clk); guard++; end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int r0, e0;
        do_reset();
        // narrow mode
        addr64 = 0;
        r0 = recs; e0 = errs;
        push_copy(0, 6, 0, 0, 16'd2048, 16'd2048, 16'd512, 16'd32, 64'h1000, 64'h8000);
        push_copy(0, 6, 1, 1, 16'hFFFF, 16'd512, 16'hFFFF, 16'hFFFF, 64'h7000_0040, 64'h0010_2000);
        push_copy(0, 8, 1, 0, 16'd64, 16'd128, 16'd4, 16'd4, 64'h0, 64'h0);
        stream.push_back(32'h7700_0001);
        stream.push_back(32'h0000_0000);
        stream.push_back(32'hFFFF_FFFF);
        stream.push_back(32'h1300_0000);
        stream.push_back(32'h5400_0006);
        stream.push_back(32'h0A00_0000);
        push_copy(0, 6, 0, 1, 16'd300, 16'd77, 16'd9, 16'd1, 64'h0000_0000_FFFF_FFFC, 64'h20);
        while (stream.size() > 0 || m_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(recs - r0 == 3, "R8", "narrow records", recs - r0, 3);
        chk(errs - e0 == 1, "R7", "narrow length errors", errs - e0, 1);
        // junk alone
        stream.push_back(32'h1200_0000);
        stream.push_back(32'h5500_0006);
        stream.push_back(32'h0B00_0000);
        while (stream.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(cmd_ready && !rec_valid && !len_err && !halted, "R10", "junk dropped",
            {cmd_ready, rec_valid, len_err, halted}, 4'b1000);
        chk(recs - r0 == 3, "R10", "no record from junk", recs - r0, 3);
        stream.push_back(32'h0A00_0000);
        push_copy(0, 6, 0, 0, 16'd8, 16'd8, 16'd1, 16'd1, 64'h40, 64'h80);
        wait_halt();
        chk(halted && !cmd_ready, "R9", "halt blocks", {halted, cmd_ready}, 2);
        chk(recs - r0 == 3, "R9", "nothing after end", recs - r0, 3);
        // wide mode
        do_reset();
        addr64 = 1;
        r0 = recs; e0 = errs;
        push_copy(1, 8, 0, 1, 16'd1024, 16'd4096, 16'd256, 16'd64,
                  64'h0000_0001_2345_6780, 64'hABCD_0000_0000_1000);
        push_copy(1, 6, 0, 0, 16'd1, 16'd1, 16'd1, 16'd1, 64'h0, 64'h0);
        stream.push_back(32'h1300_0000);
        stream.push_back(32'h5400_0008);
        stream.push_back(32'h0A00_0000);
        stream.push_back(32'h1300_0000);
        push_copy(1, 8, 1, 1, 16'h4000, 16'h0001, 16'd0, 16'd0,
                  64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0000);
        stream.push_back(32'h0A00_0000);
        wait_halt();
        chk(recs - r0 == 2, "R8", "wide records", recs - r0, 2);
        chk(errs - e0 >= 1, "R7", "wide length errors", errs - e0, 1);
        chk(halted, "R9", "wide halt", halted, 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule